// File: doc/BRIEF.md
# Memory protection region checker

This block sits beside a physical address bus and rules on every access in the same cycle it is presented. An access is an address, a kind (read, write or instruction fetch) and a privilege level. The block compares the access against a small bank of programmable regions and drives either allow or fault. It never changes the address. A denied write can therefore be stopped before it reaches memory.

Each region has a base, a power-of-two size, an enable, eight subregion-disable bits, a two-bit permission code and an execute-never bit. A configuration write port loads one region per cycle. A control write sets the global enable and the privileged background rule. When an access is refused, a capture register records the first offending address and its kind. The record holds until software clears it with a write-one-to-clear strobe.

Top module: `mpu_checker`

## Requirements
- R1: While the global enable is 0, every valid access is allowed, no access faults and nothing is captured.
- R2: The size field holds a log2 value n, and the region covers 2^n bytes. A region with n below 5 never matches.
- R3: The match test ignores the low n bits of the programmed base. A 64-byte region programmed at 0x2000_0010 covers 0x2000_0000 through 0x2000_003F and nothing else.
- R4: When several enabled regions match, only the highest-numbered one decides the access. Lower-numbered matches have no effect.
- R5: For n of 8 or more, the address eighth k = addr[n-1:n-3] is switched off by disable bit k (attribute bit 6+k). A switched-off eighth does not match, so the decision falls to the next lower matching region or to the background rule.
- R6: For n below 8 the subregion-disable bits are ignored.
- R7: An access that matches no region is allowed only if the background enable is 1 and the access is privileged. Otherwise it faults, and this includes an enabled checker with no regions configured.
- R8: Permission code 0 denies all accesses. Code 1 gives privileged read/write and no user access. Code 2 gives privileged read/write and user read-only. Code 3 gives full read/write. An instruction fetch needs read permission.
- R9: Execute-never faults instruction fetches (kind 2 or 3) only. Reads (kind 0) and writes (kind 1) to the same region follow the permission code alone.
- R10: acc_allow and acc_fault are combinational in the access inputs. They are never both 1, and acc_fault is 1 exactly when a valid access is refused.
- R11: On a fault while no record is held, the next clock edge sets fault_valid and stores the address and kind.
- R12: A held record does not change on later faults until stat_clr is pulsed. A fault in the same cycle as the clear is captured as the new record. Reset clears the record.
- R13: Attribute bit 0 enables a region. A disabled region never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Region configuration write strobe |
| cfg_region | input | RIDX_W | Index of the region written |
| cfg_base | input | ADDR_W | Region base address |
| cfg_attr | input | 17 | {xn, perm[1:0], subdis[7:0], size_log2[4:0], enable} |
| ctl_we | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Global enable value |
| ctl_bg_enable | input | 1 | Privileged background rule value |
| stat_clr | input | 1 | Write-one-to-clear of the fault record |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Physical access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 or 3 fetch |
| acc_priv | input | 1 | 1 for privileged access |
| acc_allow | output | 1 | Access permitted |
| acc_fault | output | 1 | Access refused |
| fault_valid | output | 1 | Fault record held |
| fault_addr | output | ADDR_W | Captured fault address |
| fault_kind | output | 2 | Captured access kind |

## Verification
The bench builds the block with its defaults: eight regions and 32-bit addresses. Eight regions are enough to stack three overlapping regions on one address and to use both the lowest and highest index. The 32-bit address lets random sizes run from illegal (below 32 bytes) up past the 256-byte subregion threshold. Random region layouts with accesses aimed at and just beyond each region exercise base masking, priority fall-through and the capture record. Directed cases cover the aligned window edges, the eighth boundaries and a clear arriving together with a fault.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  localparam int ATTR_W = 17;
  localparam int MIN_LOG2 = 5;
  localparam int SUB_LOG2 = 8;

  typedef enum logic [1:0] {
    AP_NONE     = 2'd0,
    AP_PRIV     = 2'd1,
    AP_PRIV_URO = 2'd2,
    AP_FULL     = 2'd3
  } ap_e;

  typedef struct packed {
    logic       xn;
    ap_e        ap;
    logic [7:0] subdis;
    logic [4:0] size_log2;
    logic       en;
  } attr_t;

  // Data permission plus the separate fetch gate.
  function automatic logic access_ok(input ap_e ap, input logic xn,
                                     input logic priv, input logic [1:0] kind);
    logic is_fetch;
    logic is_write;
    logic ok;
    is_fetch = kind[1];
    is_write = (kind == 2'b01);
    unique case (ap)
      AP_NONE:     ok = 1'b0;
      AP_PRIV:     ok = priv;
      AP_PRIV_URO: ok = priv | ~is_write;
      default:     ok = 1'b1;
    endcase
    if (is_fetch && xn) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  attr_t             attr,
  output logic              hit,
  output logic              sub_blocked
);

  function automatic logic [2:0] eighth_of(input logic [ADDR_W-1:0] a,
                                           input logic [4:0] n);
    logic [ADDR_W-1:0] s;
    if (n < 5'(SUB_LOG2)) return 3'd0;
    s = a >> (n - 5'd3);
    return s[2:0];
  endfunction

  logic [ADDR_W-1:0] mask;
  logic              legal;
  logic              in_block;
  logic [2:0]        eighth;

  assign mask     = {ADDR_W{1'b1}} << attr.size_log2;
  assign legal    = attr.en && (attr.size_log2 >= 5'(MIN_LOG2))
                    && (int'(attr.size_log2) < ADDR_W);
  assign in_block = ((addr ^ base) & mask) == '0;
  assign eighth   = eighth_of(addr, attr.size_log2);

  assign sub_blocked = legal && in_block && (attr.size_log2 >= 5'(SUB_LOG2))
                       && attr.subdis[eighth];
  assign hit         = legal && in_block && !sub_blocked;

endmodule

// File: rtl/mpu_prio_pick.sv
module mpu_prio_pick #(
  parameter int NUM = 8,
  parameter int IW  = 3
) (
  input  logic [NUM-1:0] hit,
  output logic           found,
  output logic [IW-1:0]  idx,
  output logic [NUM-1:0] onehot
);

  always_comb begin
    found  = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = 0; i < NUM; i++) begin
      if (hit[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
    if (found) onehot[idx] = 1'b1;
  end

endmodule

// File: rtl/mpu_fault_capture.sv
module mpu_fault_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [1:0]        evt_kind,
  input  logic              clr,
  output logic              valid,
  output logic [ADDR_W-1:0] addr_q,
  output logic [1:0]        kind_q
);

  logic take;
  assign take = evt && (!valid || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      addr_q <= '0;
      kind_q <= '0;
    end else if (take) begin
      valid  <= 1'b1;
      addr_q <= evt_addr;
      kind_q <= evt_kind;
    end else if (clr) begin
      valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/mpu_checker.sv
module mpu_checker
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RIDX_W-1:0] cfg_region,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ATTR_W-1:0] cfg_attr,
  input  logic              ctl_we,
  input  logic              ctl_enable,
  input  logic              ctl_bg_enable,
  input  logic              stat_clr,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_priv,
  output logic              acc_allow,
  output logic              acc_fault,
  output logic              fault_valid,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [1:0]        fault_kind
);

  logic [ADDR_W-1:0] base_q [NUM_REGIONS];
  attr_t             attr_q [NUM_REGIONS];
  logic              glob_en;
  logic              bg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        base_q[i] <= '0;
        attr_q[i] <= '0;
      end
    end else if (cfg_we && (int'(cfg_region) < NUM_REGIONS)) begin
      base_q[cfg_region] <= cfg_base;
      attr_q[cfg_region] <= attr_t'(cfg_attr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      bg_en   <= 1'b0;
    end else if (ctl_we) begin
      glob_en <= ctl_enable;
      bg_en   <= ctl_bg_enable;
    end
  end

  // Named internal events, visible to the bound checker.
  logic [NUM_REGIONS-1:0] region_hit;
  logic [NUM_REGIONS-1:0] region_subblk;
  logic [NUM_REGIONS-1:0] win_onehot;
  logic [RIDX_W-1:0]      win_idx;
  logic                   any_hit;
  attr_t                  win_attr;
  logic                   win_xn;
  logic                   permit;
  logic                   refuse_evt;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    mpu_region_match #(.ADDR_W(ADDR_W)) u_match (
      .addr        (acc_addr),
      .base        (base_q[g]),
      .attr        (attr_q[g]),
      .hit         (region_hit[g]),
      .sub_blocked (region_subblk[g])
    );
  end

  mpu_prio_pick #(.NUM(NUM_REGIONS), .IW(RIDX_W)) u_pick (
    .hit    (region_hit),
    .found  (any_hit),
    .idx    (win_idx),
    .onehot (win_onehot)
  );

  assign win_attr = attr_q[win_idx];
  assign win_xn   = win_attr.xn;

  always_comb begin
    if (!glob_en)     permit = 1'b1;
    else if (any_hit) permit = access_ok(win_attr.ap, win_attr.xn, acc_priv, acc_kind);
    else              permit = bg_en && acc_priv;
  end

  assign acc_allow  = acc_valid && permit;
  assign refuse_evt = acc_valid && !permit;
  assign acc_fault  = refuse_evt;

  mpu_fault_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (refuse_evt),
    .evt_addr (acc_addr),
    .evt_kind (acc_kind),
    .clr      (stat_clr),
    .valid    (fault_valid),
    .addr_q   (fault_addr),
    .kind_q   (fault_kind)
  );

endmodule

// File: rtl/mpu_checker_sva.sv
module mpu_checker_sva #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_valid,
  input logic [ADDR_W-1:0]      acc_addr,
  input logic [1:0]             acc_kind,
  input logic                   acc_priv,
  input logic                   acc_allow,
  input logic                   acc_fault,
  input logic                   stat_clr,
  input logic                   fault_valid,
  input logic [ADDR_W-1:0]      fault_addr,
  input logic [1:0]             fault_kind,
  input logic                   glob_en,
  input logic                   any_hit,
  input logic                   win_xn,
  input logic [NUM_REGIONS-1:0] win_onehot
);

  AST_OFF_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !glob_en |-> acc_allow && !acc_fault); // R1

  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_onehot) && (any_hit == (win_onehot != '0))); // R4

  AST_UNMATCHED_USER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && glob_en && !any_hit && !acc_priv |-> acc_fault); // R7

  AST_XN_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && glob_en && any_hit && win_xn && acc_kind[1] |-> acc_fault); // R9

  AST_ALLOW_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_allow && acc_fault) && (acc_valid || (!acc_allow && !acc_fault))); // R10

  AST_CAPTURE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault && (!fault_valid || stat_clr) |=>
      fault_valid && fault_addr == $past(acc_addr) && fault_kind == $past(acc_kind)); // R11

  AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !stat_clr |=> fault_valid && $stable(fault_addr) && $stable(fault_kind)); // R12

  AST_PRIV_UNUSED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !$rose(fault_valid)); // R1

  logic unused_ok;
  assign unused_ok = acc_priv;

endmodule

bind mpu_checker mpu_checker_sva #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_addr    (acc_addr),
  .acc_kind    (acc_kind),
  .acc_priv    (acc_priv),
  .acc_allow   (acc_allow),
  .acc_fault   (acc_fault),
  .stat_clr    (stat_clr),
  .fault_valid (fault_valid),
  .fault_addr  (fault_addr),
  .fault_kind  (fault_kind),
  .glob_en     (glob_en),
  .any_hit     (any_hit),
  .win_xn      (win_xn),
  .win_onehot  (win_onehot)
);

// File: tb/sim_mpu_checker.sv
module sim_mpu_checker;

  localparam int N  = 8;
  localparam int AW = 32;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [RW-1:0] cfg_region;
  logic [AW-1:0] cfg_base;
  logic [16:0]   cfg_attr;
  logic          ctl_we, ctl_enable, ctl_bg_enable, stat_clr;
  logic          acc_valid;
  logic [AW-1:0] acc_addr;
  logic [1:0]    acc_kind;
  logic          acc_priv;
  logic          acc_allow, acc_fault, fault_valid;
  logic [AW-1:0] fault_addr;
  logic [1:0]    fault_kind;

  always #2.5 clk = ~clk;

  mpu_checker #(.NUM_REGIONS(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
    .cfg_base(cfg_base), .cfg_attr(cfg_attr), .ctl_we(ctl_we),
    .ctl_enable(ctl_enable), .ctl_bg_enable(ctl_bg_enable), .stat_clr(stat_clr),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .acc_priv(acc_priv), .acc_allow(acc_allow), .acc_fault(acc_fault),
    .fault_valid(fault_valid), .fault_addr(fault_addr), .fault_kind(fault_kind)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [AW-1:0] sh_base [N];
  logic [16:0]   sh_attr [N];
  logic          sh_en = 0, sh_bg = 0;
  logic          ex_fv = 0;
  logic [AW-1:0] ex_fa = '0;
  logic [1:0]    ex_fk = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [16:0] mk_attr(input bit en, input int n, input logic [7:0] sd,
                                          input int ap, input bit xn);
    return {xn, 2'(ap), sd, 5'(n), en};
  endfunction

  // Independent reference: scan from the top index downward.
  function automatic logic model_permit(input logic [AW-1:0] a, input logic [1:0] k,
                                        input logic pv);
    if (!sh_en) return 1'b1;
    for (int r = N - 1; r >= 0; r--) begin
      int n;
      int e;
      int ap;
      n = int'(sh_attr[r][5:1]);
      if (!sh_attr[r][0] || n < 5) continue;
      if ((a >> n) != (sh_base[r] >> n)) continue;
      if (n >= 8) begin
        e = int'((a >> (n - 3)) & 32'd7);
        if (sh_attr[r][6 + e]) continue;
      end
      if (k[1] && sh_attr[r][16]) return 1'b0;
      ap = int'(sh_attr[r][15:14]);
      case (ap)
        0: return 1'b0;
        1: return pv;
        2: return pv || (k != 2'b01);
        default: return 1'b1;
      endcase
    end
    return pv && sh_bg;
  endfunction

  task automatic prog(input int r, input logic [AW-1:0] b, input logic [16:0] at);
    @(negedge clk);
    cfg_we = 1; cfg_region = RW'(r); cfg_base = b; cfg_attr = at;
    @(posedge clk); #1;
    cfg_we = 0;
    sh_base[r] = b; sh_attr[r] = at;
  endtask

  task automatic set_ctl(input bit en, input bit bg);
    @(negedge clk);
    ctl_we = 1; ctl_enable = en; ctl_bg_enable = bg;
    @(posedge clk); #1;
    ctl_we = 0;
    sh_en = en; sh_bg = bg;
  endtask

  task automatic access(input logic [AW-1:0] a, input logic [1:0] k, input logic pv,
                        input bit clr, input string req);
    logic exp;
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_kind = k; acc_priv = pv; stat_clr = clr;
    #1;
    exp = model_permit(a, k, pv);
    check(acc_allow == exp && acc_fault == !exp, req, "allow/fault",
          {acc_allow, acc_fault}, {exp, !exp});
    if (clr) ex_fv = 0;
    if (!exp && !ex_fv) begin
      ex_fv = 1; ex_fa = a; ex_fk = k;
    end
    @(posedge clk); #1;
    acc_valid = 0; stat_clr = 0;
  endtask

  task automatic clear_rec();
    @(negedge clk);
    stat_clr = 1;
    @(posedge clk); #1;
    stat_clr = 0;
    ex_fv = 0;
  endtask

  task automatic chk_rec(input string req);
    @(negedge clk);
    check(fault_valid == ex_fv, req, "fault_valid", fault_valid, ex_fv);
    if (ex_fv) begin
      check(fault_addr == ex_fa, req, "fault_addr", fault_addr, ex_fa);
      check(fault_kind == ex_fk, req, "fault_kind", fault_kind, ex_fk);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h5eed_1234);
    for (int i = 0; i < N; i++) begin sh_base[i] = '0; sh_attr[i] = '0; end
    rst_n = 0; cfg_we = 0; cfg_region = '0; cfg_base = '0; cfg_attr = '0;
    ctl_we = 0; ctl_enable = 0; ctl_bg_enable = 0; stat_clr = 0;
    acc_valid = 0; acc_addr = '0; acc_kind = '0; acc_priv = 0;
    repeat (3) @(negedge clk);
    check(fault_valid == 0, "R12", "reset fault_valid", fault_valid, 0);
    rst_n = 1;

    // R1: checker off
    access(32'h1234_5678, 2'd1, 0, 0, "R1");
    access(32'h0000_0000, 2'd2, 0, 0, "R1");
    chk_rec("R1");

    // R7: enabled, nothing configured
    set_ctl(1, 0);
    access(32'h0000_0100, 2'd0, 1, 0, "R7");
    chk_rec("R11");
    access(32'h0000_0200, 2'd1, 0, 0, "R12");
    chk_rec("R12");
    clear_rec();
    chk_rec("R12");
    set_ctl(1, 1);
    access(32'h0800_0000, 2'd1, 1, 0, "R7");
    access(32'h0800_0000, 2'd1, 0, 0, "R7");
    chk_rec("R11");
    clear_rec();

    // R3: base masking, 64-byte region at 0x2000_0010
    prog(0, 32'h2000_0010, mk_attr(1, 6, 8'h00, 3, 0));
    access(32'h2000_0000, 2'd1, 0, 0, "R3");
    access(32'h2000_003F, 2'd0, 0, 0, "R3");
    access(32'h2000_0040, 2'd0, 0, 0, "R3");
    access(32'h1FFF_FFFF, 2'd0, 0, 0, "R3");
    clear_rec();

    // R2: illegal size never matches
    prog(1, 32'h3000_0000, mk_attr(1, 4, 8'h00, 3, 0));
    access(32'h3000_0000, 2'd0, 0, 0, "R2");
    clear_rec();

    // R4: priority
    prog(1, 32'h4000_0040, mk_attr(1, 5, 8'h00, 0, 0));
    prog(2, 32'h4000_0000, mk_attr(1, 12, 8'h00, 3, 0));
    prog(5, 32'h4000_0000, mk_attr(1, 5, 8'h00, 0, 0));
    access(32'h4000_0000, 2'd0, 1, 0, "R4");
    access(32'h4000_0020, 2'd0, 0, 0, "R4");
    access(32'h4000_0044, 2'd1, 0, 0, "R4");
    clear_rec();

    // R5: disabled eighth falls to lower region
    prog(3, 32'h5000_0000, mk_attr(1, 8, 8'h00, 1, 0));
    prog(4, 32'h5000_0000, mk_attr(1, 8, 8'h08, 3, 0));
    access(32'h5000_0060, 2'd0, 0, 0, "R5");
    access(32'h5000_0060, 2'd0, 1, 0, "R5");
    access(32'h5000_0080, 2'd0, 0, 0, "R5");
    access(32'h5000_005F, 2'd0, 0, 0, "R5");
    clear_rec();

    // R6: small region ignores disable bits
    prog(6, 32'h6000_0000, mk_attr(1, 7, 8'hFF, 3, 0));
    access(32'h6000_0010, 2'd0, 0, 0, "R6");
    access(32'h6000_0070, 2'd1, 0, 0, "R6");

    // R9: execute-never
    prog(7, 32'h7000_0000, mk_attr(1, 5, 8'h00, 3, 1));
    access(32'h7000_0004, 2'd0, 0, 0, "R9");
    access(32'h7000_0004, 2'd1, 0, 0, "R9");
    access(32'h7000_0004, 2'd2, 1, 0, "R9");
    access(32'h7000_0008, 2'd3, 0, 0, "R9");
    chk_rec("R11");
    clear_rec();

    // R8: permission codes
    prog(7, 32'h7000_0000, mk_attr(1, 5, 8'h00, 2, 0));
    access(32'h7000_0000, 2'd0, 0, 0, "R8");
    access(32'h7000_0000, 2'd1, 0, 0, "R8");
    access(32'h7000_0000, 2'd1, 1, 0, "R8");
    access(32'h7000_0000, 2'd2, 0, 0, "R8");
    prog(7, 32'h7000_0000, mk_attr(1, 5, 8'h00, 1, 0));
    access(32'h7000_0000, 2'd0, 0, 0, "R8");
    access(32'h7000_0000, 2'd1, 1, 0, "R8");
    prog(7, 32'h7000_0000, mk_attr(1, 5, 8'h00, 0, 0));
    access(32'h7000_0000, 2'd0, 1, 0, "R8");
    clear_rec();

    // R13: disabled region falls to background
    prog(7, 32'h7000_0000, mk_attr(0, 5, 8'h00, 3, 0));
    access(32'h7000_0000, 2'd0, 0, 0, "R13");
    access(32'h7000_0000, 2'd0, 1, 0, "R13");
    chk_rec("R11");

    // R12: fault arriving with the clear becomes the new record
    access(32'h7000_0010, 2'd1, 0, 1, "R12");
    chk_rec("R12");
    clear_rec();

    // R10: random layouts
    for (int it = 0; it < 600; it++) begin
      int r;
      int n;
      logic [AW-1:0] a;
      if (it % 20 == 0) begin
        r = $urandom_range(N - 1);
        n = $urandom_range(13, 3);
        prog(r, $urandom & 32'h0003_FFFF,
             mk_attr($urandom_range(9) != 0, n, 8'($urandom), $urandom_range(3), $urandom_range(3) == 0));
      end
      if (it % 150 == 75) set_ctl($urandom_range(7) != 0, $urandom_range(1));
      r = $urandom_range(N - 1);
      n = int'(sh_attr[r][5:1]);
      if ($urandom_range(7) == 0) a = $urandom;
      else a = ((sh_base[r] >> n) << n) + ($urandom % (32'd1 << (n + 1)));
      access(a, 2'($urandom), 1'($urandom), $urandom_range(9) == 0, "R10");
      if (it % 10 == 0) chk_rec("R11");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule